// File: doc/BRIEF.md
# Configuration Register File with Keyed Vendor Region

This block is the register file behind a PCI target's configuration space. A configuration-cycle decoder in front of it presents a dword index, four byte enables, write data and a one-cycle write strobe. The block answers with read data for the indexed dword. Reads are combinational from the index. Writes land on the next rising clock edge, and only the bytes whose enable is set change. The standard header region spans byte offsets 00h to 47h. A vendor region spans E0h to FFh.

Most of the vendor region is guarded by a key word at E0h. The words from E4h through FCh accept host writes only while the low half of the key holds 4281h. The key itself can always be written. Storing any other value locks the region again. The subsystem identifier word lives at FCh. The host firmware can write it there once the region is unlocked, and a one-cycle load strobe from a power-up EEPROM loader can also set it. Whichever way it is set, its value is shown read-only at header offset 2Ch.

Top module: `cfg_space_regs`

## Requirements
- R1: After reset, dword 00h reads 7A31_1B2Ch and dword 08h reads 0401_0003h. Dword 3Ch reads 0000_0100h. Every other offset reads zero, and that includes the key, the subsystem identifier and the protected words.
- R2: Dwords 00h (device/vendor identity) and 08h (class code/revision) are read-only. Host writes to them leave their value unchanged.
- R3: Write byte enable bit k controls data bits 8k+7..8k. A byte whose enable is clear keeps its value. A read always returns the whole dword.
- R4: At dword 04h only bits 1 and 2 can be written. All other bits, including the upper status half, read zero.
- R5: Dword 10h keeps only bits 31..12 and dword 14h keeps only bits 31..16. Their lower bits read zero.
- R6: At 0Ch only bits 15..8 can be written. At 3Ch only bits 7..0 can be written, and bits 15..8 read the constant 01h. Dwords 40h and 44h are fully writable.
- R7: Bits 15..0 of the key at E0h are always writable and its upper half reads zero. The protected region is unlocked in exactly the cycles after the key's low half has been set to 4281h and before it is set to any other value.
- R8: Dwords E4h through F8h accept host writes only while unlocked. Writes made while locked are ignored.
- R9: A host write to FCh updates the subsystem identifier only while unlocked. The identifier reads back at both FCh and 2Ch.
- R10: Dword 2Ch is read-only to the host. Writes to it are ignored.
- R11: A load strobe puts the EEPROM word into the subsystem identifier whatever the lock state is. When a load and a host write to FCh fall in the same cycle, the load wins.
- R12: Unimplemented offsets (18h to 28h, 30h to 38h, 48h to DCh) read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously inside the block |
| cfg_idx | input | 6 | Dword index, equal to byte offset divided by four |
| cfg_be | input | 4 | Write byte enables, bit k for byte k |
| cfg_wr | input | 1 | Write strobe, one cycle per write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data of the indexed dword |
| ee_load | input | 1 | EEPROM loader strobe for the subsystem identifier |
| ee_ssid | input | 32 | Subsystem identifier word from the loader |

## Verification
Two functions can fall in the same clock cycle: a host write to the subsystem identifier at FCh, and the loader strobe that writes the same register. The bench raises both strobes together, with different data, while the region is unlocked. It then reads FCh and the 2Ch mirror and expects the loader's word in both places. A second collision is a key write that locks the region, followed at once by a protected write. The bench judges it by reading the protected word back and finding it unchanged.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  localparam int CFG_DW = 32;
  localparam int CFG_NB = CFG_DW / 8;
  localparam int CFG_AW = 6;

  localparam logic [CFG_AW-1:0] IX_ID     = 6'd0;
  localparam logic [CFG_AW-1:0] IX_CMD    = 6'd1;
  localparam logic [CFG_AW-1:0] IX_CLASS  = 6'd2;
  localparam logic [CFG_AW-1:0] IX_LAT    = 6'd3;
  localparam logic [CFG_AW-1:0] IX_BAR0   = 6'd4;
  localparam logic [CFG_AW-1:0] IX_BAR1   = 6'd5;
  localparam logic [CFG_AW-1:0] IX_SSMIR  = 6'd11;
  localparam logic [CFG_AW-1:0] IX_INT    = 6'd15;
  localparam logic [CFG_AW-1:0] IX_SCR0   = 6'd16;
  localparam logic [CFG_AW-1:0] IX_KEY    = 6'd56;
  localparam logic [CFG_AW-1:0] IX_PROT0  = 6'd57;
  localparam logic [CFG_AW-1:0] IX_SSID   = 6'd63;

  typedef logic [CFG_DW-1:0] dword_t;
  typedef logic [CFG_NB-1:0] bmask_t;

  function automatic dword_t be_merge(dword_t old_v, dword_t new_v,
                                      bmask_t be, dword_t wmask);
    dword_t m;
    for (int b = 0; b < CFG_NB; b++) begin
      m[8*b +: 8] = be[b] ? wmask[8*b +: 8] : 8'h00;
    end
    return (old_v & ~m) | (new_v & m);
  endfunction
endpackage

// File: rtl/cfg_wreg.sv
module cfg_wreg
  import cfg_pkg::*;
#(
  parameter dword_t WMASK = '1
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   we,
  input  bmask_t be,
  input  dword_t wd,
  output dword_t q
);
  dword_t q_r, q_n;

  always_comb begin
    q_n = q_r;
    if (we) q_n = be_merge(q_r, wd, be, WMASK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else if (we) q_r <= q_n;
  end

  assign q = q_r;
endmodule

// File: rtl/cfg_hdr.sv
module cfg_hdr
  import cfg_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID  = 16'h1B2C,
  parameter logic [15:0] DEVICE_ID  = 16'h7A31,
  parameter logic [7:0]  REVISION   = 8'h03,
  parameter logic [23:0] CLASS_CODE = 24'h040100,
  parameter logic [7:0]  INT_PIN    = 8'h01,
  parameter logic [15:0] CMD_WMASK  = 16'h0006,
  parameter int          BAR0_LOG2  = 12,
  parameter int          BAR1_LOG2  = 16,
  parameter int          N_SCR      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [CFG_AW-1:0] idx,
  input  bmask_t            be,
  input  dword_t            wd,
  input  dword_t            ssid,
  output dword_t            rdata
);
  localparam dword_t BAR0_M = ~((dword_t'(1) << BAR0_LOG2) - dword_t'(1));
  localparam dword_t BAR1_M = ~((dword_t'(1) << BAR1_LOG2) - dword_t'(1));
  localparam dword_t CMD_M  = {16'h0000, CMD_WMASK};

  dword_t cmd_q, lat_q, bar0_q, bar1_q, int_q;
  dword_t scr_q [N_SCR];

  cfg_wreg #(.WMASK(CMD_M)) u_cmd (.clk(clk), .rst_n(rst_n),
    .we(wr && idx == IX_CMD), .be(be), .wd(wd), .q(cmd_q));
  cfg_wreg #(.WMASK(32'h0000_FF00)) u_lat (.clk(clk), .rst_n(rst_n),
    .we(wr && idx == IX_LAT), .be(be), .wd(wd), .q(lat_q));
  cfg_wreg #(.WMASK(BAR0_M)) u_bar0 (.clk(clk), .rst_n(rst_n),
    .we(wr && idx == IX_BAR0), .be(be), .wd(wd), .q(bar0_q));
  cfg_wreg #(.WMASK(BAR1_M)) u_bar1 (.clk(clk), .rst_n(rst_n),
    .we(wr && idx == IX_BAR1), .be(be), .wd(wd), .q(bar1_q));
  cfg_wreg #(.WMASK(32'h0000_00FF)) u_int (.clk(clk), .rst_n(rst_n),
    .we(wr && idx == IX_INT), .be(be), .wd(wd), .q(int_q));

  for (genvar s = 0; s < N_SCR; s++) begin : g_scr
    localparam logic [CFG_AW-1:0] SIX = IX_SCR0 + CFG_AW'(s);
    cfg_wreg #(.WMASK('1)) u_scr (.clk(clk), .rst_n(rst_n),
      .we(wr && idx == SIX), .be(be), .wd(wd), .q(scr_q[s]));
  end

  always_comb begin
    rdata = '0;
    case (idx)
      IX_ID:    rdata = {DEVICE_ID, VENDOR_ID};
      IX_CMD:   rdata = cmd_q;
      IX_CLASS: rdata = {CLASS_CODE, REVISION};
      IX_LAT:   rdata = lat_q;
      IX_BAR0:  rdata = bar0_q;
      IX_BAR1:  rdata = bar1_q;
      IX_SSMIR: rdata = ssid;
      IX_INT:   rdata = {16'h0000, INT_PIN, int_q[7:0]};
      default:  rdata = '0;
    endcase
    for (int s = 0; s < N_SCR; s++) begin
      if (idx == IX_SCR0 + CFG_AW'(s)) rdata = scr_q[s];
    end
  end

  assert_cmd_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && idx == IX_CMD) |=> $stable(cmd_q));
  assert_bar0_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && idx == IX_BAR0) |=> (bar0_q & ~BAR0_M) == '0);
endmodule

// File: rtl/cfg_vnd.sv
module cfg_vnd
  import cfg_pkg::*;
#(
  parameter logic [15:0] KEY_VAL = 16'h4281,
  parameter int          N_PROT  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [CFG_AW-1:0] idx,
  input  bmask_t            be,
  input  dword_t            wd,
  input  logic              ee_load,
  input  dword_t            ee_ssid,
  output dword_t            ssid,
  output dword_t            rdata
);
  localparam dword_t KEY_M = 32'h0000_FFFF;

  dword_t key_q, key_n;
  dword_t ssid_q, ssid_n;
  logic [N_PROT-1:0][CFG_DW-1:0] prot_q;
  logic   unlocked;
  logic   wr_key, wr_ssid;

  assign wr_key   = wr && idx == IX_KEY;
  assign wr_ssid  = wr && idx == IX_SSID;
  assign unlocked = key_q[15:0] == KEY_VAL;

  always_comb begin
    key_n = key_q;
    if (wr_key) key_n = be_merge(key_q, wd, be, KEY_M);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) key_q <= '0;
    else if (wr_key) key_q <= key_n;
  end

  always_comb begin
    ssid_n = ssid_q;
    if (ee_load) ssid_n = ee_ssid;
    else if (wr_ssid && unlocked) ssid_n = be_merge(ssid_q, wd, be, '1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ssid_q <= '0;
    else if (ee_load || (wr_ssid && unlocked)) ssid_q <= ssid_n;
  end

  for (genvar p = 0; p < N_PROT; p++) begin : g_prot
    localparam logic [CFG_AW-1:0] PIX = IX_PROT0 + CFG_AW'(p);
    dword_t pq;
    cfg_wreg #(.WMASK('1)) u_prot (.clk(clk), .rst_n(rst_n),
      .we(wr && unlocked && idx == PIX), .be(be), .wd(wd), .q(pq));
    assign prot_q[p] = pq;
  end

  always_comb begin
    rdata = '0;
    if (idx == IX_KEY)  rdata = key_q;
    if (idx == IX_SSID) rdata = ssid_q;
    for (int p = 0; p < N_PROT; p++) begin
      if (idx == IX_PROT0 + CFG_AW'(p)) rdata = prot_q[p];
    end
  end

  assign ssid = ssid_q;

  assert_locked_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !unlocked && idx >= IX_PROT0 && idx < IX_SSID) |=> $stable(prot_q));
  assert_ssid_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ssid && !unlocked && !ee_load) |=> $stable(ssid_q));
  assert_ee_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ee_load |=> ssid_q == $past(ee_ssid));
  assert_key_opens_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_key && be[1:0] == 2'b11 && wd[15:0] == KEY_VAL) |=> unlocked);
endmodule

// File: rtl/cfg_space_regs.sv
module cfg_space_regs
  import cfg_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID = 16'h1B2C,
  parameter logic [15:0] DEVICE_ID = 16'h7A31,
  parameter logic [15:0] KEY_VAL   = 16'h4281,
  parameter int          N_PROT    = 6,
  parameter int          N_SCR     = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CFG_AW-1:0]   cfg_idx,
  input  logic [CFG_NB-1:0]   cfg_be,
  input  logic                cfg_wr,
  input  logic [CFG_DW-1:0]   cfg_wdata,
  output logic [CFG_DW-1:0]   cfg_rdata,
  input  logic                ee_load,
  input  logic [CFG_DW-1:0]   ee_ssid
);
  logic [1:0] rst_sync;
  logic       rst_i_n;
  dword_t     ssid, hdr_rd, vnd_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i_n = rst_sync[1];

  cfg_hdr #(.VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID), .N_SCR(N_SCR)) u_hdr (
    .clk(clk), .rst_n(rst_i_n), .wr(cfg_wr), .idx(cfg_idx), .be(cfg_be),
    .wd(cfg_wdata), .ssid(ssid), .rdata(hdr_rd));

  cfg_vnd #(.KEY_VAL(KEY_VAL), .N_PROT(N_PROT)) u_vnd (
    .clk(clk), .rst_n(rst_i_n), .wr(cfg_wr), .idx(cfg_idx), .be(cfg_be),
    .wd(cfg_wdata), .ee_load(ee_load), .ee_ssid(ee_ssid), .ssid(ssid),
    .rdata(vnd_rd));

  assign cfg_rdata = hdr_rd | vnd_rd;
endmodule

// File: tb/test_cfg_space_regs.sv
`timescale 1ns/1ps
module test_cfg_space_regs;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [5:0]  cfg_idx;
  logic [3:0]  cfg_be;
  logic        cfg_wr;
  logic [31:0] cfg_wdata, cfg_rdata;
  logic        ee_load;
  logic [31:0] ee_ssid;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [31:0] mem [64];
  bit unl;

  always #5 clk = ~clk;

  cfg_space_regs i_cfg_space_regs (.clk(clk), .rst_n(rst_n), .cfg_idx(cfg_idx),
    .cfg_be(cfg_be), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .ee_load(ee_load), .ee_ssid(ee_ssid));

  function automatic logic [31:0] wmask(int i, bit u);
    case (i)
      1:       return 32'h0000_0006;
      3:       return 32'h0000_FF00;
      4:       return 32'hFFFF_F000;
      5:       return 32'hFFFF_0000;
      15:      return 32'h0000_00FF;
      16, 17:  return 32'hFFFF_FFFF;
      56:      return 32'h0000_FFFF;
      default: return (i >= 57 && u) ? 32'hFFFF_FFFF : 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] expv(int i);
    case (i)
      0:       return 32'h7A31_1B2C;
      2:       return 32'h0401_0003;
      11:      return mem[63];
      15:      return 32'h0000_0100 | mem[15];
      default: return mem[i];
    endcase
  endfunction

  function automatic string req_of(int i);
    case (i)
      0, 2:             return "R2";
      1:                return "R4";
      3, 15, 16, 17:    return "R6";
      4, 5:             return "R5";
      11:               return "R10";
      56:               return "R7";
      63:               return "R9";
      default:          return (i >= 57) ? "R8" : "R12";
    endcase
  endfunction

  function automatic logic [31:0] bmask(logic [3:0] be);
    return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
  endfunction

  task automatic model_wr(int i, logic [3:0] be, logic [31:0] d);
    logic [31:0] m;
    m = wmask(i, unl) & bmask(be);
    mem[i] = (mem[i] & ~m) | (d & m);
    unl = (mem[56][15:0] == 16'h4281);
  endtask

  task automatic drive(int i, logic [3:0] be, logic [31:0] d, bit w, bit ld, logic [31:0] v);
    @(negedge clk);
    cfg_idx = 6'(i); cfg_be = be; cfg_wdata = d; cfg_wr = w;
    ee_load = ld; ee_ssid = v;
    @(negedge clk);
    cfg_wr = 1'b0; ee_load = 1'b0;
    if (w) model_wr(i, be, d);
    if (ld) mem[63] = v;
  endtask

  task automatic wr(int i, logic [3:0] be, logic [31:0] d);
    drive(i, be, d, 1'b1, 1'b0, 32'h0);
  endtask

  task automatic chk(int i, string tag);
    cfg_idx = 6'(i);
    #1;
    n_chk++;
    if (cfg_rdata !== expv(i)) begin
      n_bad++;
      $display("FAIL %s offset %02h: actual %08h expected %08h", tag, i*4, cfg_rdata, expv(i));
    end
  endtask

  task automatic sweep_read(string tag);
    for (int i = 0; i < 64; i++) chk(i, (tag == "") ? req_of(i) : tag);
  endtask

  initial begin
    #1ms;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'h0;
    unl = 0;
    rst_n = 1'b0; cfg_idx = '0; cfg_be = '0; cfg_wr = 1'b0; cfg_wdata = '0;
    ee_load = 1'b0; ee_ssid = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state of every offset
    sweep_read("R1");

    // Locked sweep: full-word writes to every offset
    for (int i = 0; i < 64; i++) wr(i, 4'hF, (32'h9E37_79B9 * (i + 1)) ^ 32'h0F0F_0000);
    sweep_read("");

    // Unlock, then sweep all offsets except the key
    wr(56, 4'h3, 32'hDEAD_4281);
    chk(56, "R7");
    for (int i = 0; i < 64; i++)
      if (i != 56) wr(i, 4'hF, (32'h6A09_E667 * (i + 3)) ^ 32'h00FF_00FF);
    sweep_read("");

    // R3: every byte-enable pattern on a scratch word and a protected word
    for (int b = 0; b < 16; b++) begin
      wr(16, 4'(b), 32'h1122_3344 + 32'(b) * 32'h0101_0101);
      chk(16, "R3");
      wr(58, 4'(b), 32'hC0DE_0000 ^ (32'(b) * 32'h1357_9BDF));
      chk(58, "R3");
    end

    // R7: partial key write relocks, the next protected write is ignored
    wr(56, 4'h1, 32'h0000_0000);
    wr(57, 4'hF, 32'h5555_AAAA);
    chk(57, "R7");
    wr(63, 4'hF, 32'h1234_5678);
    chk(63, "R9");
    chk(11, "R9");
    wr(56, 4'h1, 32'h0000_0081);
    wr(57, 4'hF, 32'hA5A5_5A5A);
    chk(57, "R7");

    // R11: loader and host write to FCh in the same cycle while unlocked
    drive(63, 4'hF, 32'hBBBB_BBBB, 1'b1, 1'b1, 32'h1013_ABCD);
    mem[63] = 32'h1013_ABCD;
    chk(63, "R11");
    chk(11, "R11");

    // R11: loader while locked
    wr(56, 4'hF, 32'h0000_0000);
    drive(0, 4'h0, 32'h0, 1'b0, 1'b1, 32'h7788_9900);
    chk(63, "R11");
    chk(11, "R11");
    wr(11, 4'hF, 32'hFFFF_FFFF);
    chk(11, "R10");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule